// File: doc/BRIEF.md
# Exception Priority Resolver with Promotable Maskable Source

This block looks at every pending exception request in a small microcontroller core and reports, in the same cycle, the one the CPU sequencer should service next. Requests come in three classes: reset causes, nonmaskable requests and a parameterised group of maskable requests. Each maskable request has its own local enable. The classes rank in a fixed order: resets first, then nonmaskable requests, then maskable requests. Every source is identified by a 7-bit code, and the winner's code is driven out together with a flag that separates resets from interrupts. Only interrupts require the sequencer to save context.

Two registers configure the maskable group. The first is a global mask flag that silences every maskable request. The second is a select register that names one maskable source by its code and lifts that source above the rest of the group. The other maskable sources keep their default relative order. Software reaches both registers through a write strobe, a one-bit address and an 8-bit data bus, and reads them back combinationally. The path from requests to the winner is purely combinational. Only the two registers hold state.

Top module: `exc_resolver`

## Requirements
- R1: Any set bit of `rst_req` wins over all other requests, with `exc_is_reset`=1. The order inside the class is bit0 (power-on, code 7F) over bit1 (reset pin, 7E) over bit2 (watchdog, 7D) over bit3 (clock monitor, 7C).
- R2: When no reset cause is pending, any set bit of `nmi_req` wins with `exc_is_reset`=0. The order is bit0 (illegal-opcode trap, 7B) over bit1 (software interrupt, 7A) over bit2 (external nonmaskable pin, 79). This holds whatever the mask flag and the select register hold.
- R3: A maskable request i counts only when `irq_req[i]`=1, `irq_en[i]`=1 and the mask flag is 0.
- R4: After reset the mask flag reads 1. The select register reads the code of the lowest default maskable source, which is 0x71 for 8 sources, giving a readback of 0xE2.
- R5: Maskable source i has code 0x78-i. By default, among the eligible maskable sources, the one with the higher code (the lower index) wins.
- R6: If the code held in the select register belongs to an eligible maskable source, that source wins over all other maskable sources. The remaining sources keep the default order.
- R7: If the select register holds a code that matches no eligible maskable source, the default order of R5 applies.
- R8: When `reg_wr`=1 at a clock edge, address 0 loads the mask flag from data bit 0. Address 1 loads the select register from data bits 7:1. Readback is combinational: address 0 returns {7'b0, flag}, and address 1 returns {select, 1'b0}, so bit 0 always reads 0.
- R9: With no qualified request, `exc_valid`=0, `exc_code`=0 and `exc_is_reset`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the registers |
| rst_req | input | 4 | Reset cause requests |
| nmi_req | input | 3 | Nonmaskable requests |
| irq_req | input | NUM_MASK | Maskable requests |
| irq_en | input | NUM_MASK | Local enable per maskable request |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 = mask flag, 1 = promotion select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| exc_valid | output | 1 | A request won |
| exc_code | output | 7 | Code of the winning source |
| exc_is_reset | output | 1 | The winner is a reset cause |

## Verification
The bench promotes every maskable source in turn while all of them are eligible. A resolver that ignored the select register, or that disturbed the order of the others, would grant the wrong index. It also loads out-of-range select codes, and promotes a source whose local enable is off. A design that trusted the select register without checking the request would then report a source that is not pending. Random mixes of reset, nonmaskable and maskable requests are applied with the mask flag toggled. These catch a class order that is inverted, or a mask that also silences nonmaskable requests. The reset readback of 0xE2 catches a select register that resets to zero or that returns a nonzero bit 0.

// File: rtl/exc_pkg.sv
package exc_pkg;
   localparam int CODE_W   = 7;
   localparam int RST_NUM  = 4;
   localparam int NMI_NUM  = 3;
   localparam int RST_TOP  = 8'h7F;
   localparam int NMI_TOP  = 8'h7B;
   localparam int MASK_TOP = 8'h78;

   function automatic logic [CODE_W-1:0] mask_code(input int idx);
      return CODE_W'(MASK_TOP - idx);
   endfunction
endpackage

// File: rtl/exc_regs.sv
module exc_regs
   import exc_pkg::*;
#(
   parameter int NUM_MASK = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   output logic              mask_flag,
   output logic [CODE_W-1:0] promo_sel
);
   localparam logic [CODE_W-1:0] SEL_RST = mask_code(NUM_MASK - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_flag <= 1'b1;
         promo_sel <= SEL_RST;
      end else if (reg_wr) begin
         if (reg_addr) promo_sel <= reg_wdata[7:1];
         else          mask_flag <= reg_wdata[0];
      end
   end

   always_comb begin
      if (reg_addr) reg_rdata = {promo_sel, 1'b0};
      else          reg_rdata = {7'b0, mask_flag};
   end

   AST_SEL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr) |=> (promo_sel == $past(reg_wdata[7:1]))); // R8
   AST_FLAG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !reg_addr) |=> (mask_flag == $past(reg_wdata[0]))); // R8
endmodule

// File: rtl/exc_mask_arb.sv
module exc_mask_arb
   import exc_pkg::*;
#(
   parameter int NUM_MASK = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_MASK-1:0] irq_req,
   input  logic [NUM_MASK-1:0] irq_en,
   input  logic                mask_flag,
   input  logic [CODE_W-1:0]   promo_sel,
   output logic                m_valid,
   output logic [CODE_W-1:0]   m_code,
   output logic [NUM_MASK-1:0] m_grant
);
   logic [NUM_MASK-1:0] elig;
   logic [NUM_MASK-1:0] sel_hit;
   logic [NUM_MASK-1:0] promo_win;

   assign elig = mask_flag ? '0 : (irq_req & irq_en);

   for (genvar g = 0; g < NUM_MASK; g++) begin : g_hit
      localparam logic [CODE_W-1:0] MY_CODE = mask_code(g);
      assign sel_hit[g] = (promo_sel == MY_CODE);
   end

   assign promo_win = elig & sel_hit;

   always_comb begin
      m_grant = '0;
      m_code  = '0;
      if (|promo_win) begin
         m_grant = promo_win;
      end else begin
         for (int i = NUM_MASK - 1; i >= 0; i--)
            if (elig[i]) m_grant = NUM_MASK'(1) << i;
      end
      for (int i = 0; i < NUM_MASK; i++)
         if (m_grant[i]) m_code = mask_code(i);
   end

   assign m_valid = |m_grant;

   AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(m_grant)); // R5
   AST_GRANT_ELIG: assert property (@(posedge clk) disable iff (!rst_n)
      (m_grant & ~(irq_req & irq_en)) == '0); // R3
   AST_PROMO_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (!mask_flag && |(irq_req & irq_en & sel_hit)) |-> (m_code == promo_sel)); // R6
endmodule

// File: rtl/exc_class_arb.sv
module exc_class_arb
   import exc_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [RST_NUM-1:0] rst_req,
   input  logic [NMI_NUM-1:0] nmi_req,
   input  logic               m_valid,
   input  logic [CODE_W-1:0]  m_code,
   output logic               exc_valid,
   output logic [CODE_W-1:0]  exc_code,
   output logic               exc_is_reset
);
   logic [CODE_W-1:0] rst_code;
   logic [CODE_W-1:0] nmi_code;

   always_comb begin
      rst_code = '0;
      for (int j = RST_NUM - 1; j >= 0; j--)
         if (rst_req[j]) rst_code = CODE_W'(RST_TOP - j);
      nmi_code = '0;
      for (int j = NMI_NUM - 1; j >= 0; j--)
         if (nmi_req[j]) nmi_code = CODE_W'(NMI_TOP - j);
   end

   always_comb begin
      exc_is_reset = |rst_req;
      exc_valid    = (|rst_req) | (|nmi_req) | m_valid;
      if (|rst_req)      exc_code = rst_code;
      else if (|nmi_req) exc_code = nmi_code;
      else               exc_code = m_code;
   end

   AST_RESET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (|rst_req) |-> (exc_valid && exc_is_reset && exc_code >= CODE_W'(RST_TOP - RST_NUM + 1))); // R1
   AST_NMI_OVER_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (!(|rst_req) && |nmi_req) |-> (exc_valid && !exc_is_reset
         && exc_code <= CODE_W'(NMI_TOP) && exc_code > CODE_W'(MASK_TOP))); // R2
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !exc_valid |-> (exc_code == '0 && !exc_is_reset)); // R9
endmodule

// File: rtl/exc_resolver.sv
module exc_resolver
   import exc_pkg::*;
#(
   parameter int NUM_MASK = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [3:0]          rst_req,
   input  logic [2:0]          nmi_req,
   input  logic [NUM_MASK-1:0] irq_req,
   input  logic [NUM_MASK-1:0] irq_en,
   input  logic                reg_wr,
   input  logic                reg_addr,
   input  logic [7:0]          reg_wdata,
   output logic [7:0]          reg_rdata,
   output logic                exc_valid,
   output logic [6:0]          exc_code,
   output logic                exc_is_reset
);
   if (NUM_MASK < 1 || NUM_MASK > 64) begin : g_bad_num
      $error("NUM_MASK must lie in 1..64");
   end
   if (RST_NUM != 4 || NMI_NUM != 3 || CODE_W != 7) begin : g_bad_pkg
      $error("package class sizes do not match the port list");
   end

   logic                mask_flag;
   logic [CODE_W-1:0]   promo_sel;
   logic                m_valid;
   logic [CODE_W-1:0]   m_code;
   logic [NUM_MASK-1:0] m_grant;

   exc_regs #(.NUM_MASK(NUM_MASK)) regs_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .mask_flag(mask_flag), .promo_sel(promo_sel)
   );

   exc_mask_arb #(.NUM_MASK(NUM_MASK)) marb_i (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_en(irq_en),
      .mask_flag(mask_flag), .promo_sel(promo_sel),
      .m_valid(m_valid), .m_code(m_code), .m_grant(m_grant)
   );

   exc_class_arb carb_i (
      .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .nmi_req(nmi_req),
      .m_valid(m_valid), .m_code(m_code),
      .exc_valid(exc_valid), .exc_code(exc_code), .exc_is_reset(exc_is_reset)
   );

   AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_flag && rst_req == '0 && nmi_req == '0) |-> !exc_valid); // R3
endmodule

// File: tb/exc_resolver_tb_top.sv
module exc_resolver_tb_top;
   localparam int N = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [3:0]   rst_req = '0;
   logic [2:0]   nmi_req = '0;
   logic [N-1:0] irq_req = '0;
   logic [N-1:0] irq_en = '0;
   logic         reg_wr = 1'b0;
   logic         reg_addr = 1'b0;
   logic [7:0]   reg_wdata = '0;
   logic [7:0]   reg_rdata;
   logic         exc_valid;
   logic [6:0]   exc_code;
   logic         exc_is_reset;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 0;

   int mdl_flag = 1;
   int mdl_sel  = 8'h78 - (N - 1);

   always #5 clk = ~clk;

   exc_resolver #(.NUM_MASK(N)) dut_i (
      .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .nmi_req(nmi_req),
      .irq_req(irq_req), .irq_en(irq_en), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .exc_valid(exc_valid),
      .exc_code(exc_code), .exc_is_reset(exc_is_reset)
   );

   // behavioural register model
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mdl_flag = 1;
         mdl_sel  = 8'h78 - (N - 1);
      end else if (reg_wr) begin
         if (reg_addr) mdl_sel = reg_wdata >> 1;
         else          mdl_flag = reg_wdata & 1;
      end
   end

   task automatic check(input string tag);
      int ev, ec, er, ed, win;
      @(negedge clk);
      ev = 0; ec = 0; er = 0; win = -1;
      for (int j = 3; j >= 0; j--) if (rst_req[j]) begin ec = 127 - j; er = 1; ev = 1; end
      if (!ev) for (int j = 2; j >= 0; j--) if (nmi_req[j]) begin ec = 123 - j; ev = 1; end
      if (!ev && mdl_flag == 0) begin
         for (int i = 0; i < N; i++)
            if (irq_req[i] && irq_en[i] && (120 - i) == mdl_sel) win = i;
         if (win < 0)
            for (int i = N - 1; i >= 0; i--) if (irq_req[i] && irq_en[i]) win = i;
         if (win >= 0) begin ev = 1; ec = 120 - win; end
      end
      ed = reg_addr ? (mdl_sel << 1) : mdl_flag;
      n_vec++;
      if (exc_valid !== 1'(ev) || exc_code !== 7'(ec) || exc_is_reset !== 1'(er)
          || reg_rdata !== 8'(ed)) begin
         n_bad++;
         $display("FAIL %s: got v=%0d code=%h rst=%0d rd=%h exp v=%0d code=%h rst=%0d rd=%h",
                  tag, exc_valid, exc_code, exc_is_reset, reg_rdata, ev, ec, er, ed);
      end
   endtask

   task automatic drive(input logic [3:0] r, input logic [2:0] n,
                        input logic [N-1:0] q, input logic [N-1:0] e, input logic a);
      @(posedge clk); #1;
      rst_req = r; nmi_req = n; irq_req = q; irq_en = e; reg_addr = a;
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      @(posedge clk); #1;
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1;
      reg_wr = 1'b0;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R4: reset values, R9 idle
      drive('0, '0, '0, '0, 1'b0); check("R4 flag after reset");
      drive('0, '0, '0, '0, 1'b1); check("R4 select after reset");
      drive('0, '0, '1, '1, 1'b0); check("R3 masked by reset flag");
      drive('0, '0, '0, '0, 1'b0); check("R9 idle");
      wr(1'b0, 8'h00); check("R8 clear flag");
      // R1 single resets and ordering
      for (int j = 0; j < 4; j++) begin drive(4'(1 << j), '1, '1, '1, 1'b0); check("R1 single reset"); end
      drive(4'hF, '0, '0, '0, 1'b0); check("R1 all resets");
      drive(4'hC, '0, '0, '0, 1'b0); check("R1 wdog over clkmon");
      // R2 single nmis
      for (int j = 0; j < 3; j++) begin drive('0, 3'(1 << j), '1, '1, 1'b0); check("R2 single nmi"); end
      drive('0, 3'b110, '0, '0, 1'b0); check("R2 swi over pin");
      // R5 single maskable
      for (int i = 0; i < N; i++) begin drive('0, '0, N'(1) << i, '1, 1'b0); check("R5 single maskable"); end
      drive('0, '0, 8'b1010_0100, '1, 1'b0); check("R5 default order");
      // R3 local enable
      drive('0, '0, '1, 8'b0000_0000, 1'b0); check("R3 enables off");
      drive('0, '0, 8'b0000_0011, 8'b0000_0010, 1'b0); check("R3 partial enable");
      // R6 promotion sweep
      for (int k = 0; k < N; k++) begin
         wr(1'b1, 8'((120 - k) << 1));
         drive('0, '0, '1, '1, 1'b1); check("R6 promoted wins");
         drive('0, '0, ~(N'(1) << k), '1, 1'b1); check("R6 others keep order");
      end
      wr(1'b1, 8'((120 - 5) << 1));
      drive('0, '0, 8'b0010_0110, 8'b0000_0110, 1'b1); check("R7 promoted but disabled");
      wr(1'b1, 8'h21);
      drive('0, '0, 8'b1100_0000, '1, 1'b1); check("R7 unmatched select");
      drive('0, '0, '0, '0, 1'b1); check("R8 select bit0 reads zero");
      // R2 nmi ignores mask
      wr(1'b0, 8'h01);
      drive('0, 3'b100, '1, '1, 1'b0); check("R2 nmi with flag set");
      drive('0, '0, '1, '1, 1'b0); check("R3 flag set blocks");
      wr(1'b0, 8'hFE); check("R8 flag from bit0");
      // random mixes
      for (int t = 0; t < 400; t++) begin
         if (t % 10 == 0) begin
            if ($urandom_range(0, 1)) wr(1'b1, 8'($urandom_range(0, 255)));
            else wr(1'b1, 8'((120 - $urandom_range(0, N - 1)) << 1));
         end
         if (t % 37 == 0) wr(1'b0, 8'($urandom_range(0, 3)));
         drive(($urandom_range(0, 7) == 0) ? 4'($urandom_range(0, 15)) : 4'h0,
               ($urandom_range(0, 5) == 0) ? 3'($urandom_range(0, 7)) : 3'h0,
               N'($urandom), N'($urandom), 1'($urandom_range(0, 1)));
         check("R5 R6 R7 random mix");
      end
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule